// File: doc/BRIEF.md
# Address-Space-Tagged Translation Lookaside Buffer

This block is a small, fully associative translation cache. Each stored translation carries an address-space tag and a global flag, so translations of several processes can live side by side and a context switch needs no flush. A lookup presents a virtual page number, the current 12-bit address-space tag, a load/store flag and a user/supervisor flag. One cycle later the block reports a hit (with physical frame and permissions), a permission fault, or a miss.

Each entry keeps an accessed bit and a dirty bit. They are updated inside the buffer by lookups that succeed, and a one-entry status read port exposes them so they can be written back to the page tables. New translations come in through a fill port. Placement prefers a free slot and otherwise rotates through the slots. Two invalidation commands are provided: one drops the private translations of a single address space, and the other drops everything.

Top module: `asid_tlb`

## Requirements
- R1: A lookup hits only a valid entry whose page number equals the request and whose stored 12-bit address-space tag equals the request tag in all bits. It then returns the entry's frame and permissions. A lookup with no matching entry returns hit=0 and fault=0.
- R2: An entry filled with the global flag set matches on page number alone, whatever address-space tag the lookup carries.
- R3: Each lookup result appears on the cycle after the request and is flagged by rs_valid for exactly that one cycle. rs_valid is low in every other cycle.
- R4: Permission encoding is bit0 read, bit1 write, bit2 execute, bit3 user. A store to an entry with bit1 clear returns fault=1 and hit=0. So does a user lookup (lk_user=1) to an entry with bit3 clear. hit and fault are never high together.
- R5: A lookup that hits without a fault sets the accessed bit of that entry. A faulting lookup changes neither status bit.
- R6: A store that hits without a fault sets the dirty bit of that entry. A load leaves the dirty bit unchanged.
- R7: A fill writes the lowest-numbered invalid entry and starts it with accessed=0 and dirty=0.
- R8: When every entry is valid, a fill replaces the entry chosen by a rotating pointer. The pointer is 0 after reset and advances by one, wrapping, on each such fill.
- R9: A flush by address space invalidates every valid non-global entry with that tag. All other entries are left unchanged.
- R10: A flush-all invalidates every entry.
- R11: The status port returns, one cycle after ad_idx is presented, that entry's valid flag, page number, tag, accessed bit and dirty bit.
- R12: After reset every entry is invalid and rs_valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid | input | 1 | Lookup request |
| lk_vpn | input | VPN_W | Lookup virtual page number |
| lk_asid | input | ASID_W | Current address-space tag |
| lk_store | input | 1 | 1 = store, 0 = load |
| lk_user | input | 1 | 1 = user-mode access |
| rs_valid | output | 1 | Lookup result valid |
| rs_hit | output | 1 | Translation found and allowed |
| rs_fault | output | 1 | Translation found but access not allowed |
| rs_pfn | output | PFN_W | Physical frame on hit, else 0 |
| rs_perm | output | 4 | Permissions on hit, else 0 |
| fill_valid | input | 1 | Install a translation |
| fill_vpn | input | VPN_W | Page number to install |
| fill_asid | input | ASID_W | Tag to install |
| fill_global | input | 1 | Global flag to install |
| fill_pfn | input | PFN_W | Frame to install |
| fill_perm | input | 4 | Permissions to install |
| flush_asid_valid | input | 1 | Invalidate one address space |
| flush_asid | input | ASID_W | Tag to invalidate |
| flush_all | input | 1 | Invalidate every entry |
| ad_idx | input | IDX_W | Entry selected for status read |
| ad_valid | output | 1 | Selected entry valid |
| ad_vpn | output | VPN_W | Selected entry page number |
| ad_asid | output | ASID_W | Selected entry tag |
| ad_accessed | output | 1 | Selected entry accessed bit |
| ad_dirty | output | 1 | Selected entry dirty bit |

## Verification
A lookup driven before clock edge N shows its result after edge N. The bench therefore samples rs_* at the falling edge that follows and checks one falling edge later that rs_valid has dropped. Fills, flushes and the status bits set by a lookup all take effect at that same edge. They are observed through the status port, which adds one more registered cycle: ad_idx is driven at a falling edge and read at the next one. A bench-side model of the entries, including the free-slot choice and the rotating pointer, is updated in the same order and predicts every sampled value.

// File: rtl/asid_tlb_pkg.sv
package asid_tlb_pkg;

  // Permission field layout, bit3..bit0 = user, execute, write, read
  typedef struct packed {
    logic usr;
    logic ex;
    logic wr;
    logic rd;
  } perm_t;

  localparam int PERM_W = 4;

endpackage

// File: rtl/tlb_match.sv
module tlb_match #(
  parameter int ENTRIES = 16,
  parameter int VPN_W   = 36,
  parameter int ASID_W  = 12,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic [ENTRIES-1:0] ent_valid,
  input  logic [ENTRIES-1:0] ent_global,
  input  logic [VPN_W-1:0]   ent_vpn  [ENTRIES],
  input  logic [ASID_W-1:0]  ent_asid [ENTRIES],
  input  logic [VPN_W-1:0]   lk_vpn,
  input  logic [ASID_W-1:0]  lk_asid,
  output logic               hit_any,
  output logic [IDX_W-1:0]   hit_idx
);

  logic [ENTRIES-1:0] hit_vec;

  for (genvar e = 0; e < ENTRIES; e++) begin : g_cmp
    logic vpn_eq, tag_ok;
    assign vpn_eq = (ent_vpn[e] == lk_vpn);
    assign tag_ok = ent_global[e] || (ent_asid[e] == lk_asid);
    assign hit_vec[e] = ent_valid[e] && vpn_eq && tag_ok;
  end

  // lowest index wins if duplicates were installed
  always_comb begin
    hit_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (hit_vec[i]) hit_idx = IDX_W'(i);
    end
  end

  assign hit_any = |hit_vec;

  // R1
  always_comb begin
    if (hit_any) begin
      hit_entry_chk: assert (ent_valid[hit_idx] && (ent_vpn[hit_idx] == lk_vpn));
    end
  end

endmodule

// File: rtl/tlb_victim.sv
module tlb_victim #(
  parameter int ENTRIES = 16,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [ENTRIES-1:0] ent_valid,
  input  logic               fill_fire,
  output logic [IDX_W-1:0]   victim_idx
);

  localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

  logic [IDX_W-1:0] ptr_q;
  logic [IDX_W-1:0] free_idx;
  logic             all_full;

  assign all_full = &ent_valid;

  always_comb begin
    free_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!ent_valid[i]) free_idx = IDX_W'(i);
    end
  end

  assign victim_idx = all_full ? ptr_q : free_idx;

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr_q <= '0;
    end else if (fill_fire && all_full) begin
      ptr_q <= (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
    end
  end

  // R7
  // free_first_chk
  free_first_chk: assert property (@(posedge clk) disable iff (rst)
    !all_full |-> !ent_valid[victim_idx]);

  // R8
  rr_step_chk: assert property (@(posedge clk) disable iff (rst)
    (fill_fire && all_full) |=>
      (ptr_q == (($past(ptr_q) == LAST) ? '0 : $past(ptr_q) + 1'b1)));

endmodule

// File: rtl/asid_tlb.sv
module asid_tlb
  import asid_tlb_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int VPN_W   = 36,
  parameter int PFN_W   = 40,
  parameter int ASID_W  = 12,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              lk_valid,
  input  logic [VPN_W-1:0]  lk_vpn,
  input  logic [ASID_W-1:0] lk_asid,
  input  logic              lk_store,
  input  logic              lk_user,
  output logic              rs_valid,
  output logic              rs_hit,
  output logic              rs_fault,
  output logic [PFN_W-1:0]  rs_pfn,
  output logic [3:0]        rs_perm,
  input  logic              fill_valid,
  input  logic [VPN_W-1:0]  fill_vpn,
  input  logic [ASID_W-1:0] fill_asid,
  input  logic              fill_global,
  input  logic [PFN_W-1:0]  fill_pfn,
  input  logic [3:0]        fill_perm,
  input  logic              flush_asid_valid,
  input  logic [ASID_W-1:0] flush_asid,
  input  logic              flush_all,
  input  logic [IDX_W-1:0]  ad_idx,
  output logic              ad_valid,
  output logic [VPN_W-1:0]  ad_vpn,
  output logic [ASID_W-1:0] ad_asid,
  output logic              ad_accessed,
  output logic              ad_dirty
);

  // entry state
  logic [ENTRIES-1:0] v_q, g_q, a_q, d_q;
  logic [VPN_W-1:0]   vpn_q  [ENTRIES];
  logic [ASID_W-1:0]  asid_q [ENTRIES];
  logic [PFN_W-1:0]   pfn_q  [ENTRIES];
  perm_t              perm_q [ENTRIES];

  logic             hit_any;
  logic [IDX_W-1:0] hit_idx;
  logic [IDX_W-1:0] victim_idx;
  logic             fill_fire;
  perm_t            sel_perm;
  logic             perm_bad;
  logic             lk_good;

  tlb_match #(
    .ENTRIES (ENTRIES),
    .VPN_W   (VPN_W),
    .ASID_W  (ASID_W)
  ) u_match (
    .ent_valid  (v_q),
    .ent_global (g_q),
    .ent_vpn    (vpn_q),
    .ent_asid   (asid_q),
    .lk_vpn     (lk_vpn),
    .lk_asid    (lk_asid),
    .hit_any    (hit_any),
    .hit_idx    (hit_idx)
  );

  // flushes take priority over a fill in the same cycle
  assign fill_fire = fill_valid && !flush_all && !flush_asid_valid;

  tlb_victim #(
    .ENTRIES (ENTRIES)
  ) u_victim (
    .clk        (clk),
    .rst        (rst),
    .ent_valid  (v_q),
    .fill_fire  (fill_fire),
    .victim_idx (victim_idx)
  );

  assign sel_perm = perm_q[hit_idx];
  assign perm_bad = (lk_store && !sel_perm.wr) || (lk_user && !sel_perm.usr);
  assign lk_good  = lk_valid && hit_any && !perm_bad;

  for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
    logic              v_r, g_r, a_r, d_r;
    logic [VPN_W-1:0]  vpn_r;
    logic [ASID_W-1:0] asid_r;
    logic [PFN_W-1:0]  pfn_r;
    perm_t             perm_r;
    logic              sel_wr, sel_hit, sel_kill;

    assign sel_wr   = fill_fire && (victim_idx == IDX_W'(e));
    assign sel_hit  = lk_good && (hit_idx == IDX_W'(e));
    assign sel_kill = flush_asid_valid && !g_r && (asid_r == flush_asid);

    // control bits: reset and flush
    always_ff @(posedge clk) begin
      if (rst) begin
        v_r <= 1'b0;
        a_r <= 1'b0;
        d_r <= 1'b0;
      end else if (flush_all) begin
        v_r <= 1'b0;
      end else if (sel_kill) begin
        v_r <= 1'b0;
      end else if (sel_wr) begin
        v_r <= 1'b1;
        a_r <= 1'b0;
        d_r <= 1'b0;
      end else if (sel_hit) begin
        a_r <= 1'b1;
        if (lk_store) d_r <= 1'b1;
      end
    end

    // payload: write-only storage, no reset
    always_ff @(posedge clk) begin
      if (sel_wr) begin
        g_r    <= fill_global;
        vpn_r  <= fill_vpn;
        asid_r <= fill_asid;
        pfn_r  <= fill_pfn;
        perm_r <= perm_t'(fill_perm);
      end
    end

    assign v_q[e]    = v_r;
    assign g_q[e]    = g_r;
    assign a_q[e]    = a_r;
    assign d_q[e]    = d_r;
    assign vpn_q[e]  = vpn_r;
    assign asid_q[e] = asid_r;
    assign pfn_q[e]  = pfn_r;
    assign perm_q[e] = perm_r;
  end

  // registered lookup result
  always_ff @(posedge clk) begin
    if (rst) begin
      rs_valid <= 1'b0;
      rs_hit   <= 1'b0;
      rs_fault <= 1'b0;
      rs_pfn   <= '0;
      rs_perm  <= '0;
    end else begin
      rs_valid <= lk_valid;
      rs_hit   <= lk_good;
      rs_fault <= lk_valid && hit_any && perm_bad;
      rs_pfn   <= lk_good ? pfn_q[hit_idx] : '0;
      rs_perm  <= lk_good ? sel_perm : '0;
    end
  end

  // registered status read
  always_ff @(posedge clk) begin
    if (rst) begin
      ad_valid    <= 1'b0;
      ad_vpn      <= '0;
      ad_asid     <= '0;
      ad_accessed <= 1'b0;
      ad_dirty    <= 1'b0;
    end else begin
      ad_valid    <= v_q[ad_idx];
      ad_vpn      <= vpn_q[ad_idx];
      ad_asid     <= asid_q[ad_idx];
      ad_accessed <= a_q[ad_idx];
      ad_dirty    <= d_q[ad_idx];
    end
  end

  // R3
  rs_follow_chk: assert property (@(posedge clk) disable iff (rst)
    lk_valid |=> rs_valid);

  // R3
  rs_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !lk_valid |=> !rs_valid);

  // R1
  out_gate_chk: assert property (@(posedge clk) disable iff (rst)
    (rs_hit || rs_fault) |-> rs_valid);

  // R4
  hit_fault_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(rs_hit && rs_fault));

  // R10
  flush_all_chk: assert property (@(posedge clk) disable iff (rst)
    flush_all |=> (v_q == '0));

  // R9
  flush_keep_glb_chk: assert property (@(posedge clk) disable iff (rst)
    (flush_asid_valid && !flush_all) |=> ((v_q & g_q) == $past(v_q & g_q)));

  // R6
  dirty_src_chk: assert property (@(posedge clk) disable iff (rst)
    !(lk_valid && lk_store) |=> ((d_q & ~$past(d_q)) == '0));

endmodule

// File: tb/sim_asid_tlb.sv
module sim_asid_tlb;

  localparam int N  = 8;
  localparam int VW = 8;
  localparam int PW = 8;
  localparam int AW = 12;
  localparam int IW = $clog2(N);

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          lk_valid = 1'b0;
  logic [VW-1:0] lk_vpn = '0;
  logic [AW-1:0] lk_asid = '0;
  logic          lk_store = 1'b0;
  logic          lk_user = 1'b0;
  logic          rs_valid, rs_hit, rs_fault;
  logic [PW-1:0] rs_pfn;
  logic [3:0]    rs_perm;
  logic          fill_valid = 1'b0;
  logic [VW-1:0] fill_vpn = '0;
  logic [AW-1:0] fill_asid = '0;
  logic          fill_global = 1'b0;
  logic [PW-1:0] fill_pfn = '0;
  logic [3:0]    fill_perm = '0;
  logic          flush_asid_valid = 1'b0;
  logic [AW-1:0] flush_asid = '0;
  logic          flush_all = 1'b0;
  logic [IW-1:0] ad_idx = '0;
  logic          ad_valid, ad_accessed, ad_dirty;
  logic [VW-1:0] ad_vpn;
  logic [AW-1:0] ad_asid;

  always #5 clk = ~clk;

  asid_tlb #(
    .ENTRIES (N),
    .VPN_W   (VW),
    .PFN_W   (PW),
    .ASID_W  (AW)
  ) u0 (
    .clk (clk), .rst (rst),
    .lk_valid (lk_valid), .lk_vpn (lk_vpn), .lk_asid (lk_asid),
    .lk_store (lk_store), .lk_user (lk_user),
    .rs_valid (rs_valid), .rs_hit (rs_hit), .rs_fault (rs_fault),
    .rs_pfn (rs_pfn), .rs_perm (rs_perm),
    .fill_valid (fill_valid), .fill_vpn (fill_vpn), .fill_asid (fill_asid),
    .fill_global (fill_global), .fill_pfn (fill_pfn), .fill_perm (fill_perm),
    .flush_asid_valid (flush_asid_valid), .flush_asid (flush_asid),
    .flush_all (flush_all),
    .ad_idx (ad_idx), .ad_valid (ad_valid), .ad_vpn (ad_vpn),
    .ad_asid (ad_asid), .ad_accessed (ad_accessed), .ad_dirty (ad_dirty)
  );

  // reference model of the entries
  logic          m_v [N];
  logic          m_g [N];
  logic          m_a [N];
  logic          m_d [N];
  logic [VW-1:0] m_vpn [N];
  logic [AW-1:0] m_asid [N];
  logic [PW-1:0] m_pfn [N];
  logic [3:0]    m_perm [N];
  int            m_ptr = 0;

  int n_chk = 0;
  int n_fail = 0;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic int m_find(logic [VW-1:0] vpn, logic [AW-1:0] asid);
    for (int i = 0; i < N; i++)
      if (m_v[i] && m_vpn[i] == vpn && (m_g[i] || m_asid[i] == asid)) return i;
    return -1;
  endfunction

  task automatic do_fill(logic [VW-1:0] vpn, logic [AW-1:0] asid, logic g,
                         logic [PW-1:0] pfn, logic [3:0] perm);
    int slot;
    slot = -1;
    for (int i = N - 1; i >= 0; i--) if (!m_v[i]) slot = i;
    if (slot < 0) begin
      slot = m_ptr;
      m_ptr = (m_ptr + 1) % N;
    end
    m_v[slot] = 1'b1; m_g[slot] = g; m_a[slot] = 1'b0; m_d[slot] = 1'b0;
    m_vpn[slot] = vpn; m_asid[slot] = asid; m_pfn[slot] = pfn; m_perm[slot] = perm;
    fill_vpn = vpn; fill_asid = asid; fill_global = g; fill_pfn = pfn; fill_perm = perm;
    fill_valid = 1'b1;
    @(negedge clk);
    fill_valid = 1'b0;
  endtask

  task automatic do_lookup(logic [VW-1:0] vpn, logic [AW-1:0] asid, logic st, logic usr);
    int k;
    logic e_hit, e_fault;
    string tag;
    k = m_find(vpn, asid);
    e_hit = 1'b0; e_fault = 1'b0;
    if (k >= 0) begin
      // R4 permission rule: bit1 write, bit3 user
      e_fault = (st && !m_perm[k][1]) || (usr && !m_perm[k][3]);
      e_hit = !e_fault;
    end
    if (e_fault) tag = "R4";
    else if (k >= 0 && m_g[k] && m_asid[k] != asid) tag = "R2";
    else tag = "R1";
    lk_vpn = vpn; lk_asid = asid; lk_store = st; lk_user = usr; lk_valid = 1'b1;
    @(negedge clk);
    lk_valid = 1'b0;
    chk("R3", 32'(rs_valid), 32'd1);
    chk(tag, 32'(rs_hit), 32'(e_hit));
    chk(tag, 32'(rs_fault), 32'(e_fault));
    chk(tag, 32'(rs_pfn), e_hit ? 32'(m_pfn[k]) : 32'd0);
    chk(tag, 32'(rs_perm), e_hit ? 32'(m_perm[k]) : 32'd0);
    if (e_hit) begin
      m_a[k] = 1'b1;
      if (st) m_d[k] = 1'b1;
    end
    @(negedge clk);
    chk("R3", 32'(rs_valid), 32'd0);
  endtask

  task automatic check_entries(string tag);
    for (int i = 0; i < N; i++) begin
      ad_idx = IW'(i);
      @(negedge clk);
      chk(tag, 32'(ad_valid), 32'(m_v[i]));
      if (m_v[i]) begin
        chk("R11", 32'(ad_vpn), 32'(m_vpn[i]));
        chk("R11", 32'(ad_asid), 32'(m_asid[i]));
        chk("R5", 32'(ad_accessed), 32'(m_a[i]));
        chk("R6", 32'(ad_dirty), 32'(m_d[i]));
      end
    end
  endtask

  task automatic do_flush_asid(logic [AW-1:0] asid);
    for (int i = 0; i < N; i++) if (m_v[i] && !m_g[i] && m_asid[i] == asid) m_v[i] = 1'b0;
    flush_asid = asid; flush_asid_valid = 1'b1;
    @(negedge clk);
    flush_asid_valid = 1'b0;
  endtask

  task automatic do_flush_all();
    for (int i = 0; i < N; i++) m_v[i] = 1'b0;
    flush_all = 1'b1;
    @(negedge clk);
    flush_all = 1'b0;
  endtask

  function automatic logic [AW-1:0] own_asid(int i);
    return (i % 2 == 0) ? 12'h005 : 12'hA00 + AW'(i);
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < N; i++) begin
      m_v[i] = 0; m_g[i] = 0; m_a[i] = 0; m_d[i] = 0;
      m_vpn[i] = '0; m_asid[i] = '0; m_pfn[i] = '0; m_perm[i] = '0;
    end
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // reset state
    chk("R12", 32'(rs_valid), 32'd0);
    check_entries("R12");

    // fill every slot from empty: lowest free slot first
    for (int i = 0; i < N; i++)
      do_fill(VW'(8'h10 + 3 * i), own_asid(i), (i == 3 || i == 6),
              PW'(8'hC0 + i), {i[0], i[2], i[1], 1'b1});
    check_entries("R7");

    // targeted status-bit cases
    do_lookup(m_vpn[0], own_asid(0), 1'b0, 1'b0);  // load hit: accessed only
    do_lookup(m_vpn[1], own_asid(1), 1'b1, 1'b0);  // store, no write: fault
    do_lookup(m_vpn[2], own_asid(2), 1'b1, 1'b0);  // store hit: dirty
    do_lookup(m_vpn[4], own_asid(4), 1'b0, 1'b1);  // user to supervisor: fault
    check_entries("R5");

    // sweep: each entry, several tags, all access kinds
    for (int i = 0; i < N; i++) begin
      for (int t = 0; t < 5; t++) begin
        logic [AW-1:0] a;
        case (t)
          0: a = own_asid(i);
          1: a = 12'h000;
          2: a = 12'hFFF;
          3: a = own_asid(i) ^ 12'h800;
          default: a = own_asid(i) ^ 12'h001;
        endcase
        for (int k = 0; k < 4; k++)
          do_lookup(m_vpn[i], a, k[0], k[1]);
      end
    end
    do_lookup(8'hFF, 12'h005, 1'b0, 1'b0);  // absent page
    check_entries("R6");

    // flush one address space; global entry 6 survives
    do_flush_asid(12'h005);
    check_entries("R9");
    do_lookup(m_vpn[0], 12'h005, 1'b0, 1'b0);
    do_lookup(VW'(8'h10 + 18), 12'h005, 1'b0, 1'b0);

    // refill freed slots, lowest first
    do_fill(8'h70, 12'h123, 1'b0, 8'h51, 4'b1011);
    do_fill(8'h71, 12'h123, 1'b0, 8'h52, 4'b1011);
    check_entries("R7");
    do_lookup(8'h70, 12'h123, 1'b1, 1'b1);

    // flush everything
    do_flush_all();
    check_entries("R10");
    do_lookup(VW'(8'h10 + 18), 12'h005, 1'b0, 1'b0);

    // round-robin replacement with wrap
    for (int i = 0; i < 20; i++) begin
      do_fill(VW'(8'h80 + i), 12'h300 + AW'(i), 1'b0, PW'(8'h20 + i), 4'b1111);
      if (i >= N) check_entries("R8");
    end
    for (int i = 0; i < N; i++) do_lookup(m_vpn[i], m_asid[i], 1'b1, 1'b1);
    check_entries("R8");

    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

endmodule